// File: doc/BRIEF.md
# Sticky DMA Fault Record Register

This block keeps the details of a single DMA address-translation fault in one 64-bit status word that software can read. When the translation logic reports a fault, the block stores the requester ID, the kind of request, the address type and an 8-bit reason code into fixed fields. One cycle later it sets a valid flag. Software reads the word, handles the fault, and then writes 1 to the flag to release the slot.

There is only one slot. While it is occupied, a new fault from the requester that owns the slot is merged: nothing is recorded and nothing is reported. A fault from any other requester is dropped, and a one-cycle overflow pulse reports the loss.

The flag and all stored fields survive the ordinary functional reset. They return to zero only on the power-good reset. While the functional reset is held low, incoming faults and register writes are ignored.

Top module: `fault_log_reg`

## Requirements
- R1: Bit 63 of `reg_rdata` is the valid flag. A register write with bit 63 = 1 clears the flag at the next clock edge. A write with bit 63 = 0 leaves the flag set.
- R2: An accepted fault updates the stored fields at the edge that samples it, with the flag still 0. The flag rises at the following edge, and the fields do not change at that edge.
- R3: While the slot is occupied, a fault whose 16-bit source ID equals the stored one leaves `reg_rdata` unchanged and produces no overflow pulse.
- R4: Bit 62 holds the request type: 0 for a write, 1 for a read or atomic operation.
- R5: Bits 61:60 hold the captured 2-bit address type when `devtlb_en` = 1, and read as 0 when `devtlb_en` = 0.
- R6: Bits 39:32 hold the 8-bit reason code and bits 15:0 hold the source ID. Bits 59:40 and 31:16 read as 0.
- R7: Holding `rst_n` low does not change the flag or the fields. Driving `pwr_rst_n` low sets all of `reg_rdata` to 0.
- R8: While the slot is occupied, a fault from a different source ID is dropped and the record stays unchanged. `ovf_pulse` is 1 for exactly the one cycle after the edge that dropped the fault.
- R9: If a clearing write and a fault arrive in the same cycle while the flag is set, the flag is cleared at the first edge and the fields are kept. The new fault's fields appear at the second edge with the flag still 0, and the flag rises at the third edge.
- R10: Write data in bits 62:0 has no effect on the record.
- R11: While `rst_n` is low, fault events and register writes are ignored, and `ovf_pulse` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| pwr_rst_n | input | 1 | Power-good reset, asynchronous, active low; zeroes the record |
| rst_n | input | 1 | Functional reset, active low; blocks inputs but keeps the record |
| devtlb_en | input | 1 | Enables reporting of the address-type field |
| flt_valid | input | 1 | A fault event is present this cycle |
| flt_sid | input | 16 | Requester ID of the fault |
| flt_is_read | input | 1 | 1 = read or atomic request, 0 = write |
| flt_at | input | 2 | Address type of the faulting request |
| flt_reason | input | 8 | Fault reason code |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 64 | Register write data; only bit 63 is used |
| reg_rdata | output | 64 | Current record word |
| ovf_pulse | output | 1 | One-cycle pulse for each dropped fault from another requester |

## Verification
Two functions can fall in the same cycle: a software clear of the flag and the arrival of a new fault. The bench provokes this by first filling the slot, then driving a clearing write and a fault with a different requester ID in the same cycle. It then checks the record over the next three edges: first the old fields with the flag cleared, then the new fields with the flag still 0, and finally the flag set. The same collision is also checked while the functional reset is low, where neither the write nor the fault may take effect.

// File: rtl/fault_rec_pkg.sv
package fault_rec_pkg;
  localparam int REC_W    = 64;
  localparam int SID_W    = 16;
  localparam int FR_W     = 8;
  localparam int AT_W     = 2;
  localparam int FLAG_BIT = 63;
  localparam int TYPE_BIT = 62;
  localparam int AT_LSB   = 60;
  localparam int FR_LSB   = 32;
  localparam int SID_LSB  = 0;

  typedef struct packed {
    logic [SID_W-1:0] sid;
    logic             is_read;
    logic [AT_W-1:0]  at;
    logic [FR_W-1:0]  reason;
  } fault_evt_t;

  // Builds the readable word from the stored state.
  function automatic logic [REC_W-1:0] pack_record(logic flag, fault_evt_t e, logic at_en);
    logic [REC_W-1:0] w;
    w = '0;
    w[FLAG_BIT] = flag;
    w[TYPE_BIT] = e.is_read;
    w[AT_LSB +: AT_W] = at_en ? e.at : '0;
    w[FR_LSB +: FR_W] = e.reason;
    w[SID_LSB +: SID_W] = e.sid;
    return w;
  endfunction

  // A write releases the slot only through a 1 in the flag position.
  function automatic logic clear_request(logic wr, logic [REC_W-1:0] wd);
    return wr & wd[FLAG_BIT];
  endfunction
endpackage

// File: rtl/fault_slot_ctrl.sv
module fault_slot_ctrl
  import fault_rec_pkg::*;
(
  input  logic             fault_in,
  input  logic [SID_W-1:0] fault_sid,
  input  logic             flag,
  input  logic             pend,
  input  logic             defer,
  input  logic [SID_W-1:0] owner_sid,
  input  logic             clr_hit,
  output logic             take_now,
  output logic             take_defer,
  output logic             merge,
  output logic             drop_other
);
  logic busy;
  logic same_src;

  always_comb begin
    busy       = flag | pend | defer;
    same_src   = (fault_sid == owner_sid);
    take_defer = fault_in & clr_hit;
    take_now   = fault_in & ~busy;
    merge      = fault_in & busy & ~clr_hit & same_src;
    drop_other = fault_in & busy & ~clr_hit & ~same_src;
  end
endmodule

// File: rtl/fault_store.sv
module fault_store
  import fault_rec_pkg::*;
(
  input  logic       clk,
  input  logic       pwr_rst_n,
  input  logic       take_now,
  input  logic       take_defer,
  input  logic       drop_other,
  input  logic       clr_hit,
  input  fault_evt_t evt_in,
  output fault_evt_t fld_q,
  output fault_evt_t dfr_q,
  output logic       flag_q,
  output logic       pend_q,
  output logic       defer_q,
  output logic       ovf_q
);
  always_ff @(posedge clk or negedge pwr_rst_n) begin
    if (!pwr_rst_n) begin
      fld_q   <= '0;
      dfr_q   <= '0;
      flag_q  <= 1'b0;
      pend_q  <= 1'b0;
      defer_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      if (take_now)     fld_q <= evt_in;
      else if (defer_q) fld_q <= dfr_q;
      if (take_defer)   dfr_q <= evt_in;
      pend_q  <= take_now | defer_q;
      defer_q <= take_defer;
      if (pend_q)       flag_q <= 1'b1;
      else if (clr_hit) flag_q <= 1'b0;
      ovf_q   <= drop_other;
    end
  end

  // R2: fields are settled before the flag becomes visible
  p_flag_after_fields_r2: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    $rose(flag_q) |-> $stable(fld_q));
  // R2: a capture is always followed by the flag rising
  p_pend_sets_flag_r2: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    pend_q |=> flag_q);
  // R8: overflow is a single-cycle pulse per drop
  p_ovf_pulse_r8: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    (ovf_q && !drop_other) |=> !ovf_q);
endmodule

// File: rtl/record_view.sv
module record_view
  import fault_rec_pkg::*;
(
  input  logic             flag,
  input  fault_evt_t       fld,
  input  logic             at_en,
  output logic [REC_W-1:0] rdata
);
  always_comb rdata = pack_record(flag, fld, at_en);
endmodule

// File: rtl/fault_log_reg.sv
module fault_log_reg
  import fault_rec_pkg::*;
(
  input  logic        clk,
  input  logic        pwr_rst_n,
  input  logic        rst_n,
  input  logic        devtlb_en,
  input  logic        flt_valid,
  input  logic [15:0] flt_sid,
  input  logic        flt_is_read,
  input  logic [1:0]  flt_at,
  input  logic [7:0]  flt_reason,
  input  logic        reg_wr,
  input  logic [63:0] reg_wdata,
  output logic [63:0] reg_rdata,
  output logic        ovf_pulse
);
  fault_evt_t evt_in, fld_q, dfr_q;
  logic fault_ok, wr_ok, clr_hit;
  logic flag_q, pend_q, defer_q, ovf_q;
  logic take_now, take_defer, merge, drop_other;
  logic [SID_W-1:0] owner_sid;
  logic unused_wdata;

  assign unused_wdata = ^reg_wdata[TYPE_BIT:0];

  always_comb begin
    evt_in.sid     = flt_sid;
    evt_in.is_read = flt_is_read;
    evt_in.at      = flt_at;
    evt_in.reason  = flt_reason;
    fault_ok  = flt_valid & rst_n;
    wr_ok     = reg_wr & rst_n;
    clr_hit   = clear_request(wr_ok, reg_wdata) & flag_q;
    owner_sid = defer_q ? dfr_q.sid : fld_q.sid;
  end

  fault_slot_ctrl u_ctrl (
    .fault_in  (fault_ok),
    .fault_sid (flt_sid),
    .flag      (flag_q),
    .pend      (pend_q),
    .defer     (defer_q),
    .owner_sid (owner_sid),
    .clr_hit   (clr_hit),
    .take_now  (take_now),
    .take_defer(take_defer),
    .merge     (merge),
    .drop_other(drop_other)
  );

  fault_store u_store (
    .clk       (clk),
    .pwr_rst_n (pwr_rst_n),
    .take_now  (take_now),
    .take_defer(take_defer),
    .drop_other(drop_other),
    .clr_hit   (clr_hit),
    .evt_in    (evt_in),
    .fld_q     (fld_q),
    .dfr_q     (dfr_q),
    .flag_q    (flag_q),
    .pend_q    (pend_q),
    .defer_q   (defer_q),
    .ovf_q     (ovf_q)
  );

  record_view u_view (
    .flag (flag_q),
    .fld  (fld_q),
    .at_en(devtlb_en),
    .rdata(reg_rdata)
  );

  assign ovf_pulse = ovf_q;

  // R3: a same-source merge leaves the record alone and raises no overflow
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    merge |=> ($stable(fld_q) && !ovf_pulse));
  // R1: a write without bit 63 does not drop a set flag
  p_w1c_zero_keeps_r1: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    (flag_q && reg_wr && !reg_wdata[FLAG_BIT]) |=> flag_q);
  // R9: on a collision the clear wins and the fields stay for one edge
  p_clear_first_r9: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    take_defer |=> (!flag_q && $stable(fld_q)));
  // R5: address type is hidden when the feature is off
  p_at_masked_r5: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    !devtlb_en |-> (reg_rdata[AT_LSB +: AT_W] == '0));
  // R11: no overflow report follows a cycle held in functional reset
  p_reset_quiet_r11: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    !rst_n |=> !ovf_pulse);
endmodule

// File: tb/sim_fault_log_reg.sv
`timescale 1ns/1ps
module sim_fault_log_reg;
  logic clk = 1'b0;
  logic pwr_rst_n = 1'b0, rst_n = 1'b0, devtlb_en = 1'b0;
  logic flt_valid = 1'b0, flt_is_read = 1'b0, reg_wr = 1'b0;
  logic [15:0] flt_sid = '0;
  logic [1:0]  flt_at = '0;
  logic [7:0]  flt_reason = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        ovf_pulse;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fault_log_reg u0 (.*);

  function automatic logic [63:0] exp_rec(bit f, bit t, bit [1:0] at, bit tlb,
                                          bit [7:0] fr, bit [15:0] sid);
    logic [63:0] w;
    w = (64'(f) << 63) | (64'(t) << 62) | (64'(fr) << 32) | 64'(sid);
    if (tlb) w = w | (64'(at) << 60);
    return w;
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic fault(bit v, bit [15:0] s, bit t, bit [1:0] a, bit [7:0] r);
    flt_valid = v; flt_sid = s; flt_is_read = t; flt_at = a; flt_reason = r;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] held, a_rec;
    repeat (3) tick();
    chk("R7 power-good reset", reg_rdata, 64'h0);
    pwr_rst_n = 1'b1;
    tick();
    rst_n = 1'b1;
    tick();
    chk("R7 ovf after reset", 64'(ovf_pulse), 64'h0);

    for (int i = 0; i < 32; i++) begin
      bit [15:0] sid; bit [7:0] fr; bit t; bit [1:0] at; bit tlb;
      sid = 16'(i * 16'h0841 + 3);
      fr  = 8'((i * 37) ^ 8'h5A);
      t   = i[0]; at = 2'(i >> 1); tlb = i[3];
      devtlb_en = tlb;
      fault(1, sid, t, at, fr);
      tick();
      fault(0, 0, 0, 0, 0);
      chk("R2 fields before flag", reg_rdata, exp_rec(0, t, at, tlb, fr, sid));
      tick();
      chk("R4 R5 R6 record with flag", reg_rdata, exp_rec(1, t, at, tlb, fr, sid));
      held = reg_rdata;
      reg_wr = 1; reg_wdata = 64'h7FFF_FFFF_FFFF_FFFF;
      tick();
      reg_wr = 0;
      chk("R1 R10 write zero flag ignored", reg_rdata, held);
      fault(1, sid, ~t, ~at, ~fr);
      tick();
      fault(0, 0, 0, 0, 0);
      chk("R3 merge record", reg_rdata, held);
      chk("R3 merge no ovf", 64'(ovf_pulse), 64'h0);
      fault(1, sid ^ 16'h8001, ~t, at, fr + 8'd1);
      tick();
      fault(0, 0, 0, 0, 0);
      chk("R8 drop record", reg_rdata, held);
      chk("R8 ovf pulse", 64'(ovf_pulse), 64'h1);
      tick();
      chk("R8 ovf single cycle", 64'(ovf_pulse), 64'h0);
      reg_wr = 1; reg_wdata = 64'h8000_0000_0000_0000;
      tick();
      reg_wr = 0;
      chk("R1 clear keeps fields", reg_rdata, exp_rec(0, t, at, tlb, fr, sid));
    end

    devtlb_en = 1;
    fault(1, 16'hA5A5, 1, 2'b10, 8'h33);
    tick(); tick();
    fault(0, 0, 0, 0, 0);
    a_rec = exp_rec(1, 1, 2'b10, 1, 8'h33, 16'hA5A5);
    chk("R2 setup for collision", reg_rdata, a_rec);
    reg_wr = 1; reg_wdata = 64'hFFFF_FFFF_FFFF_FFFF;
    fault(1, 16'h1234, 0, 2'b01, 8'hC7);
    tick();
    reg_wr = 0; fault(0, 0, 0, 0, 0);
    chk("R9 clear first", reg_rdata, a_rec & ~(64'h1 << 63));
    tick();
    chk("R9 deferred capture", reg_rdata, exp_rec(0, 0, 2'b01, 1, 8'hC7, 16'h1234));
    tick();
    chk("R9 deferred flag", reg_rdata, exp_rec(1, 0, 2'b01, 1, 8'hC7, 16'h1234));
    held = reg_rdata;

    rst_n = 0;
    reg_wr = 1; reg_wdata = 64'h8000_0000_0000_0000;
    fault(1, 16'h0F0F, 1, 2'b11, 8'h99);
    tick(); tick(); tick();
    chk("R7 R11 functional reset keeps record", reg_rdata, held);
    chk("R11 no ovf in reset", 64'(ovf_pulse), 64'h0);
    reg_wr = 0; fault(0, 0, 0, 0, 0);
    rst_n = 1;
    tick();
    chk("R7 record after functional reset", reg_rdata, held);
    devtlb_en = 0;
    #1;
    chk("R5 address type masked", reg_rdata, exp_rec(1, 0, 2'b01, 0, 8'hC7, 16'h1234));
    pwr_rst_n = 0;
    #1;
    chk("R7 power-good clears", reg_rdata, 64'h0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule